// File: doc/BRIEF.md
# External Bus Read Steering Decoder

This block sits between a small processor's external data bus and the devices hanging off it. Each read strobe is sent to exactly one target: a video controller register file, an internal 256-byte scratch RAM, an add-on video expansion register port, a paged expansion ROM, or a banked mega-cartridge ROM. The processor picks the target through active-low select bits in a port-1 control register. A port-2 page register supplies the upper ROM address bits.

A fixed priority chain over the registered port values makes the choice. The block drives the addresses the ROMs need. It also drives one-cycle read pulses for the two video ports, whose reads can have side effects, and it registers the returned byte. Two static configuration inputs enable the expansion ROM and the mega-cartridge. When the mega-cartridge is on, the upper half of the RAM holds cartridge registers that repeat every four bytes. The bank number for the cartridge ROM is read from one of those RAM bytes. Bus writes land in the RAM whenever the RAM is the selected target.

Top module: `xbus_read_steer`

## Requirements
- R1: After reset, rd_valid and rd_data are 0. The port-1 register resets to 0xFF and the port-2 register resets to 0x00.
- R2: When port-1 bit 3 and bit 6 are both 0, the video controller is the target, ahead of every other rule. vid_rd pulses with rd_stb and the returned byte is vid_rdata.
- R3: Otherwise, when port-1 bit 4 is 0, the RAM is the target and bus_addr indexes it directly.
- R4: With the RAM selected, cfg_mcart_en set and bus_addr bit 7 set, the RAM index is bus_addr AND 0x83, so cartridge registers repeat every 4 bytes.
- R5: In the mirrored range of R4, an address whose masked value is 0x83 returns 0xFF.
- R6: Otherwise, when port-1 bit 5 is 0, the expansion video port is the target. xvid_rd pulses with rd_stb and the returned byte is xvid_rdata.
- R7: Otherwise, when cfg_rom_en is set and port-1 bit 1 is 1, the expansion ROM is the target. erom_addr = {port2, bus_addr} and the byte is erom_rdata.
- R8: Otherwise, when cfg_mcart_en is set and port-1 bits 1 and 6 are both 0, the cartridge ROM is the target. mrom_addr = {RAM[0x81], port2[3:0], bus_addr} and the byte is mrom_rdata.
- R9: When none of the rules above applies, the returned byte is 0x00.
- R10: rd_data takes the selected byte at the clock edge where rd_stb is high. rd_valid is high exactly in the cycle after a strobe. Without a strobe, rd_data holds its value.
- R11: A write (wr_stb) stores wr_data into the RAM only when the RAM is the selected target, using the same index rule as R4. With any other target the RAM is left unchanged.
- R12: Port-register writes take effect at the next clock edge. A read in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rom_en | input | 1 | Static enable of the paged expansion ROM |
| cfg_mcart_en | input | 1 | Static enable of the mega-cartridge |
| p1_we | input | 1 | Load the port-1 control register |
| p1_wdata | input | 8 | New port-1 value |
| p2_we | input | 1 | Load the port-2 page register |
| p2_wdata | input | 8 | New port-2 value |
| rd_stb | input | 1 | Bus read strobe |
| wr_stb | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Bus address |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | rd_data was loaded by the previous strobe |
| vid_rd | output | 1 | Read pulse to the video controller |
| vid_rdata | input | 8 | Video controller byte at bus_addr |
| xvid_rd | output | 1 | Read pulse to the expansion video port |
| xvid_rdata | input | 8 | Expansion video byte at bus_addr |
| erom_addr | output | 16 | Expansion ROM address |
| erom_rdata | input | 8 | Expansion ROM byte |
| mrom_addr | output | 20 | Cartridge ROM address |
| mrom_rdata | input | 8 | Cartridge ROM byte |

## Verification
The priority chain is swept over all 256 port-1 values under all four combinations of the two enables. Port 2 is tied to a scrambled copy of port 1, so page bits vary with the selection. Each target returns data shaped by its own function of the address, which makes a wrong choice of target visible in rd_data. The address set covers the low RAM half, the first mirrored byte, the bank register, the 0x83 hole and its higher alias, and the top byte, which separates direct indexing from mirroring. Separate cases cover writes under a non-RAM target, a bank change made through a mirrored alias, a port write racing a read, and strobe-free hold cycles.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_VID  = 3'd1,
    TGT_RAM  = 3'd2,
    TGT_XVID = 3'd3,
    TGT_EROM = 3'd4,
    TGT_MROM = 3'd5
  } xbr_tgt_e;

  // port-1 select bit positions (active low except ROM_HI)
  localparam int P1_ROM_HI = 1;
  localparam int P1_VID_A  = 3;
  localparam int P1_RAM_N  = 4;
  localparam int P1_XVID_N = 5;
  localparam int P1_VID_B  = 6;
endpackage

// File: rtl/xbr_port_regs.sv
module xbr_port_regs #(
  parameter int              P1_W   = 8,
  parameter int              P2_W   = 8,
  parameter logic [P1_W-1:0] P1_RST = '1,
  parameter logic [P2_W-1:0] P2_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            p1_we,
  input  logic [P1_W-1:0] p1_wdata,
  input  logic            p2_we,
  input  logic [P2_W-1:0] p2_wdata,
  output logic [P1_W-1:0] p1_q,
  output logic [P2_W-1:0] p2_q
);
  logic [P1_W-1:0] p1_d;
  logic [P2_W-1:0] p2_d;

  always_comb begin
    p1_d = p1_we ? p1_wdata : p1_q;
    p2_d = p2_we ? p2_wdata : p2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= P1_RST;
      p2_q <= P2_RST;
    end else begin
      p1_q <= p1_d;
      p2_q <= p2_d;
    end
  end
endmodule

// File: rtl/xbr_target_sel.sv
module xbr_target_sel
  import xbr_pkg::*;
#(
  parameter int P1_W = 8
) (
  input  logic [P1_W-1:0] p1,
  input  logic            rom_en,
  input  logic            mcart_en,
  output xbr_tgt_e        tgt
);
  logic vid_hit, ram_hit, xvid_hit, erom_hit, mrom_hit;

  always_comb begin
    vid_hit  = !p1[P1_VID_A] && !p1[P1_VID_B];
    ram_hit  = !p1[P1_RAM_N];
    xvid_hit = !p1[P1_XVID_N];
    erom_hit = rom_en && p1[P1_ROM_HI];
    mrom_hit = mcart_en && !p1[P1_ROM_HI] && !p1[P1_VID_B];
    if (vid_hit)       tgt = TGT_VID;
    else if (ram_hit)  tgt = TGT_RAM;
    else if (xvid_hit) tgt = TGT_XVID;
    else if (erom_hit) tgt = TGT_EROM;
    else if (mrom_hit) tgt = TGT_MROM;
    else               tgt = TGT_NONE;
  end
endmodule

// File: rtl/xbr_xram.sv
module xbr_xram #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] MIRROR_MASK = 8'h83,
  parameter logic [ADDR_W-1:0] BANK_IDX    = 8'h81
) (
  input  logic              clk,
  input  logic              mirror_en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] bank,
  output logic              hole
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] idx;
  logic              in_mirror;

  always_comb begin
    in_mirror = mirror_en && addr[ADDR_W-1];
    idx       = in_mirror ? (addr & MIRROR_MASK) : addr;
    hole      = in_mirror && ((addr & MIRROR_MASK) == MIRROR_MASK);
    rdata     = mem[idx];
    bank      = mem[BANK_IDX];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && (idx == ADDR_W'(g))) mem[g] <= wdata;
    end
  end
endmodule

// File: rtl/xbus_read_steer.sv
module xbus_read_steer
  import xbr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int P2_W   = 8,
  parameter int PAGE_W = 4,
  parameter int EROM_W = P2_W + ADDR_W,
  parameter int MROM_W = DATA_W + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rom_en,
  input  logic              cfg_mcart_en,
  input  logic              p1_we,
  input  logic [7:0]        p1_wdata,
  input  logic              p2_we,
  input  logic [P2_W-1:0]   p2_wdata,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              vid_rd,
  input  logic [DATA_W-1:0] vid_rdata,
  output logic              xvid_rd,
  input  logic [DATA_W-1:0] xvid_rdata,
  output logic [EROM_W-1:0] erom_addr,
  input  logic [DATA_W-1:0] erom_rdata,
  output logic [MROM_W-1:0] mrom_addr,
  input  logic [DATA_W-1:0] mrom_rdata
);
  localparam logic [DATA_W-1:0] HOLE_BYTE = '1;

  logic [7:0]        p1_q;
  logic [P2_W-1:0]   p2_q;
  xbr_tgt_e          tgt;
  logic [DATA_W-1:0] ram_rdata, bank, sel_data;
  logic [DATA_W-1:0] rd_data_d;
  logic              rd_valid_d, ram_hole, ram_we;
  logic              unused_p1;

  assign unused_p1 = ^{p1_q[7], p1_q[2], p1_q[0]};

  xbr_port_regs #(.P1_W(8), .P2_W(P2_W)) u_ports (
    .clk(clk), .rst_n(rst_n),
    .p1_we(p1_we), .p1_wdata(p1_wdata),
    .p2_we(p2_we), .p2_wdata(p2_wdata),
    .p1_q(p1_q), .p2_q(p2_q)
  );

  xbr_target_sel #(.P1_W(8)) u_sel (
    .p1(p1_q), .rom_en(cfg_rom_en), .mcart_en(cfg_mcart_en), .tgt(tgt)
  );

  assign ram_we = wr_stb && (tgt == TGT_RAM);

  xbr_xram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .mirror_en(cfg_mcart_en), .we(ram_we), .addr(bus_addr),
    .wdata(wr_data), .rdata(ram_rdata), .bank(bank), .hole(ram_hole)
  );

  always_comb begin
    erom_addr = {p2_q, bus_addr};
    mrom_addr = {bank, p2_q[PAGE_W-1:0], bus_addr};
    vid_rd    = rd_stb && (tgt == TGT_VID);
    xvid_rd   = rd_stb && (tgt == TGT_XVID);
    unique case (tgt)
      TGT_VID:  sel_data = vid_rdata;
      TGT_RAM:  sel_data = ram_hole ? HOLE_BYTE : ram_rdata;
      TGT_XVID: sel_data = xvid_rdata;
      TGT_EROM: sel_data = erom_rdata;
      TGT_MROM: sel_data = mrom_rdata;
      default:  sel_data = '0;
    endcase
    rd_data_d  = rd_stb ? sel_data : rd_data;
    rd_valid_d = rd_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_data_d;
      rd_valid <= rd_valid_d;
    end
  end
endmodule

// File: rtl/xbr_checker.sv
module xbr_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_rom_en,
  input logic              cfg_mcart_en,
  input logic [7:0]        p1_q,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              vid_rd,
  input logic              xvid_rd
);
  logic vid_sel, ram_sel, none_sel;

  always_comb begin
    vid_sel  = !p1_q[3] && !p1_q[6];
    ram_sel  = !vid_sel && !p1_q[4];
    none_sel = !vid_sel && p1_q[4] && p1_q[5]
               && !(cfg_rom_en && p1_q[1])
               && !(cfg_mcart_en && !p1_q[1] && !p1_q[6]);
  end

  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);  // R10
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);  // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));  // R10
  AST_VID_PULSE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    vid_rd |-> rd_stb && vid_sel);  // R2
  AST_XVID_PULSE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    xvid_rd |-> rd_stb && !vid_sel && p1_q[4] && !p1_q[5]);  // R6
  AST_ONE_VIDEO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vid_rd, xvid_rd}));  // R2
  AST_MIRROR_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && ram_sel && cfg_mcart_en && bus_addr[ADDR_W-1]
     && ((bus_addr & 8'h83) == 8'h83)) |=> (rd_data == '1));  // R5
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && none_sel) |=> (rd_data == '0));  // R9
endmodule

bind xbus_read_steer xbr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rom_en(cfg_rom_en), .cfg_mcart_en(cfg_mcart_en),
  .p1_q(p1_q), .rd_stb(rd_stb), .bus_addr(bus_addr), .rd_data(rd_data),
  .rd_valid(rd_valid), .vid_rd(vid_rd), .xvid_rd(xvid_rd)
);

// File: tb/test_xbus_read_steer.sv
`timescale 1ns/1ps
module test_xbus_read_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rom_en = 1'b0, cfg_mcart_en = 1'b0;
  logic        p1_we = 1'b0, p2_we = 1'b0;
  logic [7:0]  p1_wdata = '0, p2_wdata = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0]  bus_addr = '0, wr_data = '0;
  logic [7:0]  rd_data, vid_rdata, xvid_rdata, erom_rdata, mrom_rdata;
  logic        rd_valid, vid_rd, xvid_rd;
  logic [15:0] erom_addr;
  logic [19:0] mrom_addr;

  int n_chk = 0, n_bad = 0;
  logic [7:0] shadow [256];
  logic [7:0] m_p1 = 8'hFF, m_p2 = 8'h00;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] erom_fn(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mrom_fn(input logic [19:0] a);
    return a[19:12] + a[7:0] + {4'h0, a[11:8]} + 8'h21;
  endfunction

  assign vid_rdata  = bus_addr ^ 8'hC3;
  assign xvid_rdata = ~bus_addr;
  assign erom_rdata = erom_fn(erom_addr);
  assign mrom_rdata = mrom_fn(mrom_addr);

  xbus_read_steer i_xbus_read_steer (
    .clk(clk), .rst_n(rst_n), .cfg_rom_en(cfg_rom_en), .cfg_mcart_en(cfg_mcart_en),
    .p1_we(p1_we), .p1_wdata(p1_wdata), .p2_we(p2_we), .p2_wdata(p2_wdata),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_addr(bus_addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .vid_rd(vid_rd), .vid_rdata(vid_rdata),
    .xvid_rd(xvid_rd), .xvid_rdata(xvid_rdata), .erom_addr(erom_addr),
    .erom_rdata(erom_rdata), .mrom_addr(mrom_addr), .mrom_rdata(mrom_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] p1, input logic [7:0] p2,
                                       input logic [7:0] a);
    logic [7:0] mi;
    if (!p1[3] && !p1[6]) return a ^ 8'hC3;
    if (!p1[4]) begin
      if (cfg_mcart_en && a[7]) begin
        mi = a & 8'h83;
        if (mi == 8'h83) return 8'hFF;
        return shadow[mi];
      end
      return shadow[a];
    end
    if (!p1[5]) return ~a;
    if (cfg_rom_en && p1[1]) return erom_fn({p2, a});
    if (cfg_mcart_en && !p1[1] && !p1[6]) return mrom_fn({shadow[8'h81], p2[3:0], a});
    return 8'h00;
  endfunction

  task automatic set_ports(input logic [7:0] v1, input logic [7:0] v2);
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
    p1_we = 1; p1_wdata = v1; p2_we = 1; p2_wdata = v2;
    @(posedge clk); #1;
    p1_we = 0; p2_we = 0;
    m_p1 = v1; m_p2 = v2;
  endtask

  task automatic do_read(input logic [7:0] a);
    logic [7:0] e;
    logic ev, ex;
    @(negedge clk);
    rd_stb = 1; wr_stb = 0; bus_addr = a;
    e  = model(m_p1, m_p2, a);
    ev = !m_p1[3] && !m_p1[6];
    ex = !ev && m_p1[4] && !m_p1[5];
    #1;
    check("R2/R6 video pulses", {vid_rd, xvid_rd}, {ev, ex});
    check("R7 erom_addr", erom_addr, {m_p2, a});
    check("R8 mrom_addr", mrom_addr, {shadow[8'h81], m_p2[3:0], a});
    @(posedge clk); #1;
    check("R3/R4/R5/R9 rd_data", rd_data, e);
    check("R10 rd_valid", rd_valid, 1);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    rd_stb = 0; wr_stb = 1; bus_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_stb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist [8];
    logic [7:0] held;
    alist = '{8'h00, 8'h45, 8'h7F, 8'h80, 8'h81, 8'h83, 8'hC7, 8'hFF};
    repeat (3) @(posedge clk);
    #1;
    check("R1 rd_valid reset", rd_valid, 0);
    check("R1 rd_data reset", rd_data, 0);
    @(negedge clk); rst_n = 1;
    // R1: port-1 resets to 0xFF -> no target without enables; port-2 is 0
    do_read(8'h12);
    check("R1 p2 reset via erom_addr", erom_addr[15:8], 8'h00);

    // preload RAM (direct indexing, R3/R11)
    set_ports(8'hEF, 8'h00);
    for (int a = 0; a < 256; a++) begin
      do_write(8'(a), 8'(a * 7 + 3));
      shadow[a] = 8'(a * 7 + 3);
    end

    // exhaustive priority sweep: R2..R9
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      cfg_rom_en = c[0]; cfg_mcart_en = c[1];
      for (int p = 0; p < 256; p++) begin
        set_ports(8'(p), 8'(p) ^ 8'h9C);
        for (int k = 0; k < 8; k++) do_read(alist[k]);
      end
    end

    // R10: hold without strobe
    held = rd_data;
    @(negedge clk); rd_stb = 0; bus_addr = 8'h33;
    @(posedge clk); #1;
    check("R10 hold data", rd_data, held);
    check("R10 valid low", rd_valid, 0);

    // R11: write ignored with video target selected
    @(negedge clk); cfg_rom_en = 0; cfg_mcart_en = 0;
    set_ports(8'h00, 8'h00);
    do_write(8'h10, 8'hAA);
    set_ports(8'hEF, 8'h00);
    do_read(8'h10);
    check("R11 write ignored", rd_data, shadow[8'h10]);

    // R11/R4: mirrored write to 0x85 updates bank at 0x81
    @(negedge clk); cfg_mcart_en = 1;
    do_write(8'h85, 8'h3C);
    shadow[8'h81] = 8'h3C;
    set_ports(8'h38, 8'h07);
    do_read(8'h12);
    check("R8 bank via mirror", mrom_addr, {8'h3C, 4'h7, 8'h12});

    // R12: port write in same cycle as read uses old value
    set_ports(8'hEF, 8'h00);
    @(negedge clk);
    p1_we = 1; p1_wdata = 8'h00; rd_stb = 1; bus_addr = 8'h22;
    @(posedge clk); #1;
    p1_we = 0; rd_stb = 0;
    check("R12 old port value", rd_data, shadow[8'h22]);
    m_p1 = 8'h00;
    do_read(8'h22);
    check("R12 new port value", rd_data, 8'h22 ^ 8'hC3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule